// File: doc/BRIEF.md
# I2C Register Access Target with 24-bit Addressing

This block is an I2C slave that gives an external master read and write access to a 24-bit wide internal register space. Each access carries a 24-bit register address. The top address byte picks one of several internal address spaces, and the low 16 bits pick a location within that space. Data words are 24 bits wide and move as three bytes, most significant byte first.

A write frame has this shape: START, device address with the write bit, three address bytes, three data bytes, STOP. The internal write strobe fires once, when the last data byte has been received. A read first sends a dummy write that carries only the three address bytes. A repeated START and the device address with the read bit follow. The block then requests the word from the internal bus and shifts it out.

SCL and SDA are synchronised into the block's clock domain. SDA is driven only through an open-drain pull-low enable.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset the SDA pull-down enable and both internal strobes are low.
- R2: A device address byte whose upper seven bits equal the DEV_ADDR parameter is acknowledged. Any other device address is not acknowledged, and the rest of that frame is ignored: no acknowledge and no strobe until the next START.
- R3: A write frame issues exactly one reg_we_o pulse, after the third data byte. At that pulse reg_space_o holds address byte one (register address bits 23:16), reg_addr_o holds address bytes two and three, and reg_wdata_o holds the three data bytes in arrival order with the first byte in bits 23:16.
- R4: Every address and data byte that follows a matching write-direction device address is acknowledged by pulling SDA low for the ninth bit slot.
- R5: An address latched by a dummy write survives a repeated START. A matching read-direction device address then raises reg_re_o for one cycle with that space and offset.
- R6: The read word is returned as three bytes, bits 23:16 first, MSB first within each byte. It is taken from reg_rdata_i in the cycle after reg_re_o.
- R7: A NACK from the master after a read byte ends the data phase. SDA is released, and any further clocked byte reads as all ones.
- R8: A STOP before the third data byte of a write frame produces no reg_we_o pulse.
- R9: A START in the middle of a frame discards the partial frame, and the bytes that follow are decoded as a new frame starting from the device address.
- R10: The SDA pull-down enable changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | I2C clock line, asynchronous |
| sda_i | input | 1 | I2C data line, asynchronous |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| reg_space_o | output | SPACE_W | Address space select |
| reg_addr_o | output | OFS_W | Offset within the space |
| reg_wdata_o | output | DATA_W | Write data |
| reg_we_o | output | 1 | Single-cycle write strobe |
| reg_re_o | output | 1 | Single-cycle read request |
| reg_rdata_i | input | DATA_W | Read data, valid the cycle after reg_re_o |

## Verification
The SDA-drive timing property assumes that the master holds SCL low for longer than the synchroniser delay plus one cycle, because the block reacts to a falling SCL a few clocks late. It also assumes that the master changes SDA only while SCL is low, except to form START and STOP. The bench master keeps SCL in each phase for eight block clocks and moves its own SDA only in the low phase. It also never issues STOP while the target is pulling the line, so every edge the checker sees comes from the target's own sequencing.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECV,
    ST_ACK,
    ST_SEND,
    ST_MACK
  } tgt_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d, scl_s, sda_s;

  assign scl_s = scl_q[STAGES-1];
  assign sda_s = sda_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_d;
  assign scl_fall_o = ~scl_s & scl_d;
  assign start_o    = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_o     = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_frame_ctrl.sv
module i2c_frame_ctrl
  import i2c_reg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2c,
  parameter int SPACE_W = 8,
  parameter int OFS_W   = 16,
  parameter int DATA_W  = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_rise_i,
  input  logic               scl_fall_i,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  output logic [SPACE_W-1:0] reg_space_o,
  output logic [OFS_W-1:0]   reg_addr_o,
  output logic [DATA_W-1:0]  reg_wdata_o,
  output logic               reg_we_o,
  output logic               reg_re_o,
  input  logic [DATA_W-1:0]  reg_rdata_i
);
  localparam int AW         = SPACE_W + OFS_W;
  localparam int ADDR_BYTES = AW / 8;
  localparam int DATA_BYTES = DATA_W / 8;
  localparam int CNT_W      = $clog2(ADDR_BYTES + DATA_BYTES + 2);
  localparam int IDX_W      = $clog2(DATA_BYTES + 1);
  localparam logic [CNT_W-1:0] LAST_ADDR = CNT_W'(ADDR_BYTES);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(ADDR_BYTES + DATA_BYTES);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(DATA_BYTES - 1);

  tgt_state_e        state_q;
  logic [2:0]        bit_cnt_q;
  logic [CNT_W-1:0]  byte_cnt_q;
  logic [7:0]        shreg_q;
  logic [7:0]        byte_val;
  logic              rw_q, done_q, ack_pend_q, rd_cap_q, mack_ok_q, oe_q;
  logic [AW-1:0]     addr_q;
  logic [DATA_W-1:0] wdata_q, rd_word_q;
  logic [IDX_W-1:0]  rd_idx_q;
  logic              we_q, re_q;

  assign byte_val = {shreg_q[6:0], sda_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      bit_cnt_q  <= '0;
      byte_cnt_q <= '0;
      shreg_q    <= '0;
      rw_q       <= 1'b0;
      done_q     <= 1'b0;
      ack_pend_q <= 1'b0;
      rd_cap_q   <= 1'b0;
      mack_ok_q  <= 1'b0;
      oe_q       <= 1'b0;
      addr_q     <= '0;
      wdata_q    <= '0;
      rd_word_q  <= '0;
      rd_idx_q   <= '0;
      we_q       <= 1'b0;
      re_q       <= 1'b0;
    end else begin
      we_q     <= 1'b0;
      re_q     <= 1'b0;
      rd_cap_q <= re_q;
      if (rd_cap_q) rd_word_q <= reg_rdata_i;
      if (start_i) begin
        // address register is kept: a dummy write feeds the following read
        state_q    <= ST_RECV;
        bit_cnt_q  <= '0;
        byte_cnt_q <= '0;
        done_q     <= 1'b0;
        oe_q       <= 1'b0;
      end else if (stop_i) begin
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
      end else begin
        unique case (state_q)
          ST_RECV: begin
            if (scl_rise_i && !done_q) begin
              shreg_q   <= byte_val;
              bit_cnt_q <= bit_cnt_q + 3'd1;
              if (bit_cnt_q == 3'd7) begin
                done_q     <= 1'b1;
                byte_cnt_q <= byte_cnt_q + 1'b1;
                if (byte_cnt_q == '0) begin
                  ack_pend_q <= (byte_val[7:1] == DEV_ADDR);
                  rw_q       <= byte_val[0];
                  if (byte_val[7:1] == DEV_ADDR && byte_val[0]) re_q <= 1'b1;
                end else if (!rw_q && byte_cnt_q <= LAST_ADDR) begin
                  addr_q     <= {addr_q[AW-9:0], byte_val};
                  ack_pend_q <= 1'b1;
                end else if (!rw_q && byte_cnt_q <= LAST_DATA) begin
                  wdata_q    <= {wdata_q[DATA_W-9:0], byte_val};
                  ack_pend_q <= 1'b1;
                  if (byte_cnt_q == LAST_DATA) we_q <= 1'b1;
                end else begin
                  ack_pend_q <= 1'b0;
                end
              end
            end
            if (scl_fall_i && done_q) begin
              done_q    <= 1'b0;
              bit_cnt_q <= '0;
              state_q   <= ack_pend_q ? ST_ACK : ST_IDLE;
              oe_q      <= ack_pend_q;
            end
          end
          ST_ACK: begin
            if (scl_fall_i) begin
              if (rw_q) begin
                state_q  <= ST_SEND;
                rd_idx_q <= '0;
                oe_q     <= ~rd_word_q[DATA_W-1];
              end else begin
                state_q <= ST_RECV;
                oe_q    <= 1'b0;
              end
            end
          end
          ST_SEND: begin
            if (scl_fall_i) begin
              rd_word_q <= rd_word_q << 1;
              if (bit_cnt_q == 3'd7) begin
                state_q <= ST_MACK;
                oe_q    <= 1'b0;
              end else begin
                bit_cnt_q <= bit_cnt_q + 3'd1;
                oe_q      <= ~rd_word_q[DATA_W-2];
              end
            end
          end
          ST_MACK: begin
            if (scl_rise_i) mack_ok_q <= ~sda_i;
            if (scl_fall_i) begin
              if (mack_ok_q && rd_idx_q < LAST_IDX) begin
                state_q   <= ST_SEND;
                rd_idx_q  <= rd_idx_q + 1'b1;
                bit_cnt_q <= '0;
                oe_q      <= ~rd_word_q[DATA_W-1];
              end else begin
                state_q <= ST_IDLE;
                oe_q    <= 1'b0;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o    = oe_q;
  assign reg_space_o = addr_q[AW-1 -: SPACE_W];
  assign reg_addr_o  = addr_q[OFS_W-1:0];
  assign reg_wdata_o = wdata_q;
  assign reg_we_o    = we_q;
  assign reg_re_o    = re_q;
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target #(
  parameter logic [6:0] DEV_ADDR    = 7'h2c,
  parameter int         SYNC_STAGES = 2,
  parameter int         SPACE_W     = 8,
  parameter int         OFS_W       = 16,
  parameter int         DATA_W      = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  output logic [SPACE_W-1:0] reg_space_o,
  output logic [OFS_W-1:0]   reg_addr_o,
  output logic [DATA_W-1:0]  reg_wdata_o,
  output logic               reg_we_o,
  output logic               reg_re_o,
  input  logic [DATA_W-1:0]  reg_rdata_i
);
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  i2c_frame_ctrl #(
    .DEV_ADDR (DEV_ADDR),
    .SPACE_W  (SPACE_W),
    .OFS_W    (OFS_W),
    .DATA_W   (DATA_W)
  ) ctrl_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .scl_rise_i  (scl_rise),
    .scl_fall_i  (scl_fall),
    .start_i     (start_det),
    .stop_i      (stop_det),
    .sda_i       (sda_s),
    .sda_oe_o    (sda_oe_o),
    .reg_space_o (reg_space_o),
    .reg_addr_o  (reg_addr_o),
    .reg_wdata_o (reg_wdata_o),
    .reg_we_o    (reg_we_o),
    .reg_re_o    (reg_re_o),
    .reg_rdata_i (reg_rdata_i)
  );
endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk #(
  parameter int SPACE_W = 8,
  parameter int OFS_W   = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               scl_i,
  input logic               sda_oe_o,
  input logic               reg_we_o,
  input logic               reg_re_o,
  input logic [SPACE_W-1:0] reg_space_o,
  input logic [OFS_W-1:0]   reg_addr_o
);
  // R10
  oe_on_low_scl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_i);

  // R3
  we_single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);

  // R3
  we_addr_settled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> ($stable(reg_space_o) && $stable(reg_addr_o)));

  // R5
  re_single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_re_o |=> !reg_re_o);

  // R5
  re_before_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_re_o |-> !sda_oe_o);

  // R2
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_o && reg_re_o));
endmodule

bind i2c_reg_target i2c_reg_target_chk #(
  .SPACE_W (SPACE_W),
  .OFS_W   (OFS_W)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .scl_i       (scl_i),
  .sda_oe_o    (sda_oe_o),
  .reg_we_o    (reg_we_o),
  .reg_re_o    (reg_re_o),
  .reg_space_o (reg_space_o),
  .reg_addr_o  (reg_addr_o)
);

// File: tb/i2c_reg_target_tb_top.sv
module i2c_reg_target_tb_top;
  localparam logic [6:0] DEV = 7'h2c;
  localparam int Q = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic        sda_line;
  logic        sda_oe_o, reg_we_o, reg_re_o;
  logic [7:0]  reg_space_o;
  logic [15:0] reg_addr_o;
  logic [23:0] reg_wdata_o, reg_rdata_i;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit oe_bad = 1'b0;
  logic oe_prev = 1'b0;
  logic [47:0] exp_wr_q[$];
  logic [23:0] exp_rd_q[$];

  always #10 clk_i = ~clk_i;

  assign sda_line = sda_m & ~sda_oe_o;

  function automatic logic [23:0] model(input logic [7:0] sp, input logic [15:0] ad);
    return {ad[7:0], sp, ad[15:8]} ^ 24'ha5c33c;
  endfunction
  assign reg_rdata_i = model(reg_space_o, reg_addr_o);

  i2c_reg_target #(.DEV_ADDR(DEV)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe_o), .reg_space_o(reg_space_o), .reg_addr_o(reg_addr_o),
    .reg_wdata_o(reg_wdata_o), .reg_we_o(reg_we_o), .reg_re_o(reg_re_o),
    .reg_rdata_i(reg_rdata_i)
  );

  task automatic check(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops scoreboard entries as strobes appear
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (sda_oe_o != oe_prev && scl_m) oe_bad = 1'b1;
      oe_prev <= sda_oe_o;
      if (reg_we_o) begin
        if (exp_wr_q.size() == 0) check(1'b0, "R8 unexpected write", {reg_space_o, reg_addr_o, reg_wdata_o}, '0);
        else begin
          logic [47:0] e;
          e = exp_wr_q.pop_front();
          check({reg_space_o, reg_addr_o, reg_wdata_o} == e, "R3 write", {reg_space_o, reg_addr_o, reg_wdata_o}, e);
        end
      end
      if (reg_re_o) begin
        if (exp_rd_q.size() == 0) check(1'b0, "R5 unexpected read", {reg_space_o, reg_addr_o}, '0);
        else begin
          logic [23:0] e;
          e = exp_rd_q.pop_front();
          check({reg_space_o, reg_addr_o} == e, "R5 read address", {reg_space_o, reg_addr_o}, e);
        end
      end
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic hold(); repeat (Q) @(negedge clk_i); endtask

  task automatic i2c_start();
    sda_m = 1'b1; hold(); scl_m = 1'b1; hold(); sda_m = 1'b0; hold(); scl_m = 1'b0; hold();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; hold(); scl_m = 1'b1; hold(); sda_m = 1'b1; hold();
  endtask

  task automatic put_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hold(); scl_m = 1'b1; hold(); hold(); scl_m = 1'b0; hold();
    end
    sda_m = 1'b1; hold(); scl_m = 1'b1; hold();
    acked = !sda_line;
    hold(); scl_m = 1'b0; hold();
  endtask

  task automatic get_byte(input bit nack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hold(); scl_m = 1'b1; hold(); b[i] = sda_line; hold(); scl_m = 1'b0; hold();
    end
    sda_m = nack; hold(); scl_m = 1'b1; hold(); hold(); scl_m = 1'b0; hold();
    sda_m = 1'b1;
  endtask

  task automatic send_chk(input logic [7:0] b, input bit exp_ack, input string tag);
    bit a;
    put_byte(b, a);
    check(a == exp_ack, tag, 48'(a), 48'(exp_ack));
  endtask

  task automatic write_frame(input logic [7:0] sp, input logic [15:0] ad, input logic [23:0] d);
    exp_wr_q.push_back({sp, ad, d});
    i2c_start();
    send_chk({DEV, 1'b0}, 1'b1, "R2 device ack");
    send_chk(sp, 1'b1, "R4 addr ack");
    send_chk(ad[15:8], 1'b1, "R4 addr ack");
    send_chk(ad[7:0], 1'b1, "R4 addr ack");
    send_chk(d[23:16], 1'b1, "R4 data ack");
    send_chk(d[15:8], 1'b1, "R4 data ack");
    send_chk(d[7:0], 1'b1, "R4 data ack");
    i2c_stop();
  endtask

  task automatic dummy_then_read(input logic [7:0] sp, input logic [15:0] ad);
    exp_rd_q.push_back({sp, ad});
    i2c_start();
    send_chk({DEV, 1'b0}, 1'b1, "R2 device ack");
    send_chk(sp, 1'b1, "R4 addr ack");
    send_chk(ad[15:8], 1'b1, "R4 addr ack");
    send_chk(ad[7:0], 1'b1, "R4 addr ack");
    i2c_start();
    send_chk({DEV, 1'b1}, 1'b1, "R5 read device ack");
  endtask

  initial begin
    logic [7:0] b0, b1, b2;
    logic [23:0] m;
    repeat (5) @(negedge clk_i);
    check(sda_oe_o == 1'b0, "R1 oe", 48'(sda_oe_o), 0);
    check(reg_we_o == 1'b0, "R1 we", 48'(reg_we_o), 0);
    check(reg_re_o == 1'b0, "R1 re", 48'(reg_re_o), 0);
    rst_ni = 1'b1;
    hold();

    // R3: two writes with distinct patterns
    write_frame(8'h12, 16'h3456, 24'habcdef);
    write_frame(8'h03, 16'h0001, 24'h000080);

    // R6: full read, MSB byte first
    dummy_then_read(8'h12, 16'h3456);
    m = model(8'h12, 16'h3456);
    get_byte(1'b0, b0); get_byte(1'b0, b1); get_byte(1'b1, b2);
    check({b0, b1, b2} == m, "R6 read word", 48'({b0, b1, b2}), 48'(m));
    i2c_stop();

    // R2: wrong device address ignored
    i2c_start();
    send_chk({7'h2d, 1'b0}, 1'b0, "R2 mismatch nack");
    send_chk(8'h44, 1'b0, "R2 ignored byte");
    send_chk(8'h55, 1'b0, "R2 ignored byte");
    i2c_stop();

    // R8: STOP after two data bytes
    i2c_start();
    send_chk({DEV, 1'b0}, 1'b1, "R8 device ack");
    send_chk(8'h09, 1'b1, "R8 addr ack");
    send_chk(8'h08, 1'b1, "R8 addr ack");
    send_chk(8'h07, 1'b1, "R8 addr ack");
    send_chk(8'h66, 1'b1, "R8 data ack");
    send_chk(8'h77, 1'b1, "R8 data ack");
    i2c_stop();
    hold();
    check(exp_wr_q.size() == 0, "R8 no write", 48'(exp_wr_q.size()), 0);

    // R9: START in mid-frame restarts decoding
    i2c_start();
    send_chk({DEV, 1'b0}, 1'b1, "R9 device ack");
    send_chk(8'h77, 1'b1, "R9 addr ack");
    write_frame(8'h05, 16'h0a0b, 24'h112233);

    // R7: NACK after the first read byte ends the data phase
    dummy_then_read(8'h07, 16'h0100);
    m = model(8'h07, 16'h0100);
    get_byte(1'b1, b0);
    check(b0 == m[23:16], "R7 first byte", 48'(b0), 48'(m[23:16]));
    get_byte(1'b1, b1);
    check(b1 == 8'hff, "R7 released after nack", 48'(b1), 48'hff);
    i2c_stop();

    hold(); hold();
    check(exp_wr_q.size() == 0, "R3 all writes seen", 48'(exp_wr_q.size()), 0);
    check(exp_rd_q.size() == 0, "R5 all reads seen", 48'(exp_rd_q.size()), 0);
    check(!oe_bad, "R10 oe moved with scl high", 48'(oe_bad), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule